// File: doc/BRIEF.md
# Page Translation Unit with TLB and Hardware Table Fetch

The block maps a 14-bit virtual address to a 12-bit physical address for a paged memory with 64-byte pages. A small set-associative translation cache is looked up first. A hit answers without touching memory. On a miss the unit reads one page-table entry over a simple read port, at the table base plus the virtual page number. It checks the entry's valid and permission bits, installs valid entries in the cache, and returns either a physical address or one of two fault indications.

Requests use a valid/ready handshake, and so do responses. The unit handles one translation at a time. A flush input empties the cache in one cycle. Software pulses it after the table base changes. Fault handling, paging and data caching belong to the surrounding system.

Top module: `xlat_unit`

## Requirements
- R1: The low 6 bits of the virtual address pass unchanged into the low 6 bits of the physical address, and the physical page number forms bits 11:6.
- R2: A translation that hits in the cache raises rsp_valid_o in the second cycle after the request is accepted, and issues no memory read.
- R3: A miss issues exactly one single-cycle mem_req_o at address (table base captured at acceptance + virtual page number) modulo 4096. The unit then waits any number of cycles for mem_rvalid_i.
- R4: The page-table entry is 10 bits: bit 9 valid, bit 8 supervisor-only, bit 7 readable, bit 6 writable, bits 5:0 physical page number. If the valid bit is clear, the response has rsp_page_fault_o=1, rsp_prot_fault_o=0 and a zero address, and nothing is installed in the cache, so a repeat of the access misses again.
- R5: An access is refused when a user-mode request targets a supervisor-only page, a write targets a page without the writable bit, or a read targets a page without the readable bit. A refused access returns rsp_prot_fault_o=1 with a zero address, on a hit and on a miss alike.
- R6: The cache has 4 sets of 4 ways. The set is the virtual page number's bits 1:0 and the tag is bits 7:2. A valid fetched entry is installed, and later accesses to that page hit and return the cached entry even if memory has since changed.
- R7: A fill goes to the lowest-numbered empty way of its set. When the set is full, it goes to the way named by a per-set round-robin pointer. The pointer starts at 0 and advances by one for each such eviction.
- R8: A flush pulse empties every way and resets the round-robin pointers, so the next access to any page misses.
- R9: req_ready_o is high only when no translation is in flight. A response holds rsp_valid_o and its fields steady until rsp_ready_i is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Empty the translation cache |
| ptbr_i | input | 12 | Page-table base address |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Unit idle, request accepted |
| req_vaddr_i | input | 14 | Virtual address |
| req_write_i | input | 1 | Access is a write |
| req_user_i | input | 1 | Access comes from user mode |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response consumed |
| rsp_paddr_o | output | 12 | Physical address, zero on fault |
| rsp_page_fault_o | output | 1 | Entry not valid |
| rsp_prot_fault_o | output | 1 | Access refused by permissions |
| mem_req_o | output | 1 | Page-table read strobe |
| mem_addr_o | output | 12 | Page-table entry address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 10 | Page-table entry read data |

## Verification
The hardest state to reach from the ports is a full set that must evict by round-robin. It takes four distinct pages that share low page-number bits, and then further conflicting pages. The order of those later misses decides which older page is lost, and only a following miss or hit shows the loss. The stimulus walks one set through five and more conflicting pages, and revisits earlier pages in between. A behavioural model of the cache contents predicts, at every step, whether a memory read must appear. The memory responder varies its latency from read to read, so the wait for read data is exercised at several lengths.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int unsigned VA_W   = 14;
  localparam int unsigned PA_W   = 12;
  localparam int unsigned OFF_W  = 6;
  localparam int unsigned VPN_W  = VA_W - OFF_W;
  localparam int unsigned PPN_W  = PA_W - OFF_W;
  localparam int unsigned MEM_AW = 12;
  localparam int unsigned PTE_W  = PPN_W + 4;
  localparam int unsigned PTE_V  = PPN_W + 3;

  // field order matches the entry's low bits so a cast decodes it
  typedef struct packed {
    logic             sup;
    logic             rd;
    logic             wr;
    logic [PPN_W-1:0] ppn;
  } tlb_data_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOK, ST_MREQ, ST_MWAIT, ST_RESP
  } xlat_state_e;

  function automatic logic access_ok(tlb_data_t d, logic is_write, logic is_user);
    return !(is_user && d.sup) && (is_write ? d.wr : d.rd);
  endfunction
endpackage

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int unsigned NUM_WAYS = 4,
  localparam int unsigned WAY_W = $clog2(NUM_WAYS)
) (
  input  logic [NUM_WAYS-1:0] valid_i,
  input  logic [WAY_W-1:0]    rr_i,
  output logic [WAY_W-1:0]    way_o,
  output logic                use_rr_o
);
  // lowest empty way wins, otherwise the round-robin pointer
  always_comb begin
    use_rr_o = 1'b1;
    way_o    = rr_i;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (!valid_i[w]) begin
        use_rr_o = 1'b0;
        way_o    = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb import xlat_pkg::*; #(
  parameter int unsigned NUM_SETS = 4,
  parameter int unsigned NUM_WAYS = 4,
  parameter int unsigned TAG_W    = 6,
  localparam int unsigned SET_W = $clog2(NUM_SETS),
  localparam int unsigned WAY_W = $clog2(NUM_WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [SET_W-1:0] lk_set_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  output logic             hit_o,
  output tlb_data_t        hit_data_o,
  input  logic             fill_i,
  input  logic [SET_W-1:0] fill_set_i,
  input  logic [TAG_W-1:0] fill_tag_i,
  input  tlb_data_t        fill_data_i
);
  logic [NUM_WAYS-1:0] valid_q [NUM_SETS];
  logic [TAG_W-1:0]    tag_q   [NUM_SETS][NUM_WAYS];
  tlb_data_t           data_q  [NUM_SETS][NUM_WAYS];
  logic [WAY_W-1:0]    rr_q    [NUM_SETS];
  logic [NUM_WAYS-1:0] way_hit;
  logic [WAY_W-1:0]    vic_way;
  logic                vic_rr;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
    assign way_hit[w] = valid_q[lk_set_i][w] && (tag_q[lk_set_i][w] == lk_tag_i);
  end

  always_comb begin
    hit_data_o = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (way_hit[w]) hit_data_o = tlb_data_t'(hit_data_o | data_q[lk_set_i][w]);
    end
  end
  assign hit_o = |way_hit;

  xlat_victim #(.NUM_WAYS(NUM_WAYS)) i_victim (
    .valid_i (valid_q[fill_set_i]),
    .rr_i    (rr_q[fill_set_i]),
    .way_o   (vic_way),
    .use_rr_o(vic_rr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        valid_q[s] <= '0;
        rr_q[s]    <= '0;
      end
    end else if (flush_i) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        valid_q[s] <= '0;
        rr_q[s]    <= '0;
      end
    end else if (fill_i) begin
      valid_q[fill_set_i][vic_way] <= 1'b1;
      if (vic_rr) begin
        rr_q[fill_set_i] <= (rr_q[fill_set_i] == WAY_W'(NUM_WAYS - 1)) ? '0
                                                                       : rr_q[fill_set_i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_i && !flush_i) begin
      tag_q[fill_set_i][vic_way]  <= fill_tag_i;
      data_q[fill_set_i][vic_way] <= fill_data_i;
    end
  end

  // R8
  flush_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !hit_o);

  // R6
  hit_unique_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(way_hit));
endmodule

// File: rtl/xlat_unit.sv
module xlat_unit import xlat_pkg::*; #(
  parameter int unsigned TLB_SETS = 4,
  parameter int unsigned TLB_WAYS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic [MEM_AW-1:0] ptbr_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [VA_W-1:0]   req_vaddr_i,
  input  logic              req_write_i,
  input  logic              req_user_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [PA_W-1:0]   rsp_paddr_o,
  output logic              rsp_page_fault_o,
  output logic              rsp_prot_fault_o,
  output logic              mem_req_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [PTE_W-1:0]  mem_rdata_i
);
  localparam int unsigned SET_W = $clog2(TLB_SETS);
  localparam int unsigned TAG_W = VPN_W - SET_W;

  xlat_state_e       state_q;
  logic [VA_W-1:0]   va_q;
  logic              wr_q, usr_q;
  logic [MEM_AW-1:0] base_q;
  logic [PA_W-1:0]   paddr_q;
  logic              pf_q, pv_q;

  logic [VPN_W-1:0]  vpn;
  logic [OFF_W-1:0]  off;
  logic              hit;
  tlb_data_t         hit_data, pte_data, chk_data;
  logic              pte_valid, fill, chk_ok;

  assign vpn       = va_q[VA_W-1:OFF_W];
  assign off       = va_q[OFF_W-1:0];
  assign pte_data  = tlb_data_t'(mem_rdata_i[PTE_W-2:0]);
  assign pte_valid = mem_rdata_i[PTE_V];
  assign fill      = (state_q == ST_MWAIT) && mem_rvalid_i && pte_valid;
  assign chk_data  = (state_q == ST_LOOK) ? hit_data : pte_data;
  assign chk_ok    = access_ok(chk_data, wr_q, usr_q);

  xlat_tlb #(.NUM_SETS(TLB_SETS), .NUM_WAYS(TLB_WAYS), .TAG_W(TAG_W)) i_tlb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush_i),
    .lk_set_i   (vpn[SET_W-1:0]),
    .lk_tag_i   (vpn[VPN_W-1:SET_W]),
    .hit_o      (hit),
    .hit_data_o (hit_data),
    .fill_i     (fill),
    .fill_set_i (vpn[SET_W-1:0]),
    .fill_tag_i (vpn[VPN_W-1:SET_W]),
    .fill_data_i(pte_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      va_q    <= '0;
      wr_q    <= 1'b0;
      usr_q   <= 1'b0;
      base_q  <= '0;
      paddr_q <= '0;
      pf_q    <= 1'b0;
      pv_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          va_q    <= req_vaddr_i;
          wr_q    <= req_write_i;
          usr_q   <= req_user_i;
          base_q  <= ptbr_i;
          state_q <= ST_LOOK;
        end
        ST_LOOK: if (hit) begin
          pf_q    <= 1'b0;
          pv_q    <= !chk_ok;
          paddr_q <= chk_ok ? {chk_data.ppn, off} : '0;
          state_q <= ST_RESP;
        end else begin
          state_q <= ST_MREQ;
        end
        ST_MREQ: state_q <= ST_MWAIT;
        ST_MWAIT: if (mem_rvalid_i) begin
          pf_q    <= !pte_valid;
          pv_q    <= pte_valid && !chk_ok;
          paddr_q <= (pte_valid && chk_ok) ? {chk_data.ppn, off} : '0;
          state_q <= ST_RESP;
        end
        ST_RESP: if (rsp_ready_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o      = (state_q == ST_IDLE);
  assign rsp_valid_o      = (state_q == ST_RESP);
  assign rsp_paddr_o      = paddr_q;
  assign rsp_page_fault_o = pf_q;
  assign rsp_prot_fault_o = pv_q;
  assign mem_req_o        = (state_q == ST_MREQ);
  assign mem_addr_o       = base_q + MEM_AW'(vpn);

  // R9
  rsp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_paddr_o)
                                    && $stable(rsp_page_fault_o) && $stable(rsp_prot_fault_o));

  // R9
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o);

  // R3
  mem_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  // R4
  fault_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !(rsp_page_fault_o && rsp_prot_fault_o));

  // R5
  fault_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && (rsp_page_fault_o || rsp_prot_fault_o) |-> rsp_paddr_o == '0);
endmodule

// File: tb/test_xlat_unit.sv
module test_xlat_unit;
  import xlat_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n, flush;
  logic [MEM_AW-1:0] ptbr;
  logic              req_valid, req_ready, req_write, req_user;
  logic [VA_W-1:0]   req_vaddr;
  logic              rsp_valid, rsp_ready, pf, pv;
  logic [PA_W-1:0]   paddr;
  logic              mem_req, mem_rvalid;
  logic [MEM_AW-1:0] mem_addr;
  logic [PTE_W-1:0]  mem_rdata;

  xlat_unit i_xlat_unit (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .ptbr_i(ptbr),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_vaddr_i(req_vaddr),
    .req_write_i(req_write), .req_user_i(req_user),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_paddr_o(paddr),
    .rsp_page_fault_o(pf), .rsp_prot_fault_o(pv),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i(mem_rdata)
  );

  int checks = 0, fails = 0;
  bit done = 0, busy = 0, exp_miss = 0;

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // page table held by address
  logic [PTE_W-1:0] pt [int];

  function automatic logic [PTE_W-1:0] gen_pte(int vpn, int salt);
    logic v, s, r, w;
    logic [5:0] p;
    v = !(vpn == 'h0B || vpn == 'h2B);
    s = (vpn == 5);
    r = (vpn != 6);
    w = (vpn != 7);
    p = 6'(((vpn * 5 + 3) ^ salt) & 63);
    return {v, s, r, w, p};
  endfunction

  task automatic fill_pt(input int base, input int salt);
    for (int v = 0; v < 256; v++) pt[(base + v) & 'hFFF] = gen_pte(v, salt);
  endtask

  // memory responder with varying latency
  int mem_reads = 0;
  int last_addr = -1;
  initial begin
    mem_rvalid = 1'b0;
    mem_rdata  = '0;
    forever begin
      @(negedge clk);
      if (rst_n && mem_req) begin
        last_addr = int'(mem_addr);
        mem_reads++;
        repeat (1 + mem_reads % 4) @(negedge clk);
        mem_rvalid = 1'b1;
        mem_rdata  = pt.exists(last_addr) ? pt[last_addr] : '0;
        @(negedge clk);
        mem_rvalid = 1'b0;
      end
    end
  end

  // behavioural cache model
  bit               m_v   [4][4];
  int               m_tag [4][4];
  logic [PTE_W-1:0] m_d   [4][4];
  int               m_rr  [4];

  task automatic model_flush();
    for (int s = 0; s < 4; s++) begin
      m_rr[s] = 0;
      for (int w = 0; w < 4; w++) m_v[s][w] = 0;
    end
  endtask

  // per-clock comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (busy) chk(!req_ready, "R9", "ready while busy", int'(req_ready), 0);
      if (mem_req) chk(exp_miss, "R2", "memory read without miss", 1, 0);
    end
  end

  task automatic xlat(input logic [13:0] va, input bit wr, input bit usr, input string rq, input int hold = 0);
    int vpn, set, tg, hw, eaddr, r0, cyc, vw;
    logic [PTE_W-1:0] e;
    bit miss, epf, epv, ok;
    logic [11:0] epa;
    vpn = int'(va[13:6]); set = vpn % 4; tg = vpn / 4; hw = -1;
    for (int w = 0; w < 4; w++) if (m_v[set][w] && m_tag[set][w] == tg) hw = w;
    miss  = (hw < 0);
    eaddr = (int'(ptbr) + vpn) & 'hFFF;
    if (!miss) e = m_d[set][hw];
    else begin
      e = pt.exists(eaddr) ? pt[eaddr] : '0;
      if (e[9]) begin
        vw = -1;
        for (int w = 3; w >= 0; w--) if (!m_v[set][w]) vw = w;
        if (vw < 0) begin vw = m_rr[set]; m_rr[set] = (m_rr[set] + 1) % 4; end
        m_v[set][vw] = 1; m_tag[set][vw] = tg; m_d[set][vw] = e;
      end
    end
    epf = miss && !e[9];
    ok  = !(usr && e[8]) && (wr ? e[6] : e[7]);
    epv = !epf && !ok;
    epa = (epf || epv) ? 12'h0 : {e[5:0], va[5:0]};

    r0 = mem_reads;
    @(negedge clk);
    exp_miss  = miss;
    req_vaddr = va; req_write = wr; req_user = usr; req_valid = 1'b1;
    rsp_ready = (hold == 0);
    @(posedge clk);
    #1 req_valid = 1'b0; busy = 1;
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (!rsp_valid && cyc < 1000);
    chk(paddr == epa, rq, "paddr", int'(paddr), int'(epa));
    chk(pf == epf, rq, "page fault", int'(pf), int'(epf));
    chk(pv == epv, rq, "prot fault", int'(pv), int'(epv));
    chk((mem_reads - r0) == int'(miss), rq, "memory reads", mem_reads - r0, int'(miss));
    if (!miss) chk(cyc == 2, rq, "hit latency", cyc, 2);
    else chk(last_addr == eaddr, rq, "entry address", last_addr, eaddr);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(rsp_valid && paddr == epa && pf == epf && pv == epv, "R9", "held response", int'(paddr), int'(epa));
    end
    rsp_ready = 1'b1;
    @(posedge clk);
    #1 busy = 0; exp_miss = 0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    model_flush();
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R9 watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    rst_n = 0; flush = 0; ptbr = 12'h100; req_valid = 0; req_vaddr = '0;
    req_write = 0; req_user = 0; rsp_ready = 1;
    fill_pt('h100, 0); fill_pt('h300, 'h2A); fill_pt('hFF0, 'h15);
    model_flush();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    chk(req_ready == 1, "R9", "reset ready", int'(req_ready), 1);
    chk(rsp_valid == 0, "R9", "reset rsp_valid", int'(rsp_valid), 0);
    chk(mem_req == 0, "R3", "reset mem_req", int'(mem_req), 0);

    xlat({8'h03, 6'h15}, 0, 1, "R3");
    xlat({8'h03, 6'h2A}, 1, 1, "R2");
    pt['h103] = 10'h3C5;
    xlat({8'h03, 6'h07}, 0, 1, "R6");

    xlat({8'h0B, 6'h01}, 0, 1, "R4");
    xlat({8'h0B, 6'h01}, 0, 0, "R4");

    xlat({8'h05, 6'h10}, 0, 1, "R5");
    xlat({8'h05, 6'h10}, 0, 0, "R5");
    xlat({8'h07, 6'h11}, 1, 0, "R5");
    xlat({8'h06, 6'h12}, 0, 0, "R5");
    xlat({8'h06, 6'h12}, 1, 1, "R5");

    // set 0: fill four ways, then evict in round-robin order
    xlat({8'h00, 6'h01}, 0, 0, "R7");
    xlat({8'h04, 6'h02}, 0, 0, "R7");
    xlat({8'h08, 6'h03}, 0, 0, "R7");
    xlat({8'h0C, 6'h04}, 0, 0, "R7");
    xlat({8'h10, 6'h05}, 0, 0, "R7");
    xlat({8'h04, 6'h06}, 0, 0, "R7");
    xlat({8'h00, 6'h07}, 0, 0, "R7");
    xlat({8'h04, 6'h08}, 0, 0, "R7");
    xlat({8'h08, 6'h09}, 0, 0, "R7");

    xlat({8'h10, 6'h01}, 0, 0, "R9", 3);

    do_flush();
    xlat({8'h03, 6'h3F}, 0, 0, "R8");
    xlat({8'h08, 6'h00}, 0, 0, "R8");

    ptbr = 12'h300;
    do_flush();
    xlat({8'h21, 6'h33}, 0, 0, "R3");
    xlat({8'h21, 6'h0C}, 1, 0, "R1");

    ptbr = 12'hFF0;
    do_flush();
    xlat({8'h20, 6'h2D}, 0, 1, "R3");
    xlat({8'h2B, 6'h00}, 0, 1, "R4");

    ptbr = 12'h100;
    do_flush();
    for (int i = 0; i < 24; i++)
      xlat({8'(i * 37), 6'(i * 13)}, (i % 3) == 0, i[0], "R1");

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule